// File: doc/BRIEF.md
# Split/Joinable Interval Timer

This block is a general-purpose interval timer built from two 16-bit halves, A and B. A three-bit configuration field either joins the halves into a single 32-bit counter or leaves them as two independent 16-bit counters. Each counter counts down from its load value to zero, or up from zero to its load value. It runs either once (one-shot) or repeatedly (periodic). Options per half add a match event, a snapshot of a free-running cycle count taken at time-out, and a start that waits for an external trigger pulse.

Software talks to the block through a simple 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from the read address. Misaligned addresses, where the two low address bits are non-zero, are ignored on write and read as zero. The register byte offsets are:

- 0x00: configuration.
- 0x04: control.
- 0x08 and 0x0C: mode for A and for B.
- 0x10 and 0x14: load for A and for B.
- 0x18 and 0x1C: match for A and for B.
- 0x20 and 0x24: timer value for A and for B, read-only.
- 0x28 and 0x2C: free-running count for A and for B, read-only.
- 0x30: raw event status.
- 0x34: mask.
- 0x38: clear, write-only.
- 0x3C: masked status.

Each mode register uses these bits:

- [1:0]: kind. The value 2 is periodic; any other value is one-shot.
- [2]: count up.
- [3]: match enable.
- [4]: snapshot enable.
- [5]: wait for trigger.

The event bits are:

- Bit 0: A time-out.
- Bit 1: A match.
- Bit 2: B time-out.
- Bit 3: B match.

Top module: `gp_timer_pair`

## Requirements
- R1: After reset, configuration (0x00), control (0x04), raw status (0x30) and masked status (0x3C) read 0, and `irq` is 0. A configuration value of 0 means joined mode.
- R2: In joined mode (configuration 0 or 1), a write to 0x10 stores bits [31:16] as the B load value and bits [15:0] as the A load value. A read of 0x14 then returns the upper half, and a read of 0x10 returns the full 32-bit value.
- R3: In joined mode, a read of 0x20 returns the 32-bit count {B half, A half}, with a borrow propagating across bit 16. After enabling with load L counting down, the count read n edges after the start edge is L-n.
- R4: In down counting (mode bit 2 = 0), setting the enable bit loads L and the counter times out at 0. Status bit 0 becomes visible L+2 edges after the edge that wrote the enable bit.
- R5: In up counting (mode bit 2 = 1), the counter starts at 0 and times out at L, with the same first-time-out latency of L+2 edges.
- R6: In one-shot mode, time-out clears the enable bit (control bit 0 for A, bit 1 for B). No further time-outs follow. The timer value holds at the terminal count: 0 counting down, L counting up.
- R7: In periodic mode (kind 2), the counter reloads on the clock after time-out, so time-outs recur every L+1 cycles.
- R8: With mode bit 3 set, status bit 1 is set one edge after the cycle in which the running count equals the match value. With bit 3 clear, bit 1 is never set.
- R9: With mode bit 4 set, the timer register returns the free-running count captured at time-out. The free-running count is 0 on the start edge and advances every enabled cycle.
- R10: With mode bit 5 set, an enabled timer holds its count until a one-cycle trigger pulse arrives. A pulse in the cycle after edge j starts counting at edge j+1.
- R11: Status bits are set by events and cleared by writing 1 to the same bit at 0x38; a set wins over a clear. Masked status is raw status AND mask (0x34), and `irq` is the OR of the masked status.
- R12: Writes to configuration are ignored while either enable bit is set. Writes to a half's mode, load and match registers are ignored while that half is enabled, and B's are also ignored while A is enabled in joined mode.
- R13: In split mode (configuration 4), writes to 0x10 store only the low 16 bits. A and B count independently. B events use status bits 2 and 3, and a B one-shot clears only control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| trig_a | input | 1 | Start trigger pulse for half A (or the joined counter) |
| trig_b | input | 1 | Start trigger pulse for half B |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The core function is swept over every combination of count direction and run kind, for load values 0, 1, 2, 5 and 9. The first time-out latency separates an off-by-one in the start load from one in terminal detection. The second period of periodic runs separates a reload-on-timeout counter from one that restarts a cycle late. Separate patterns check three behaviours:

- Match values counted both up and down, which separates equality against the live count from equality against the load.
- A trigger delayed by three cycles together with snapshot, which separates a count that truly held from one that ran while waiting.
- A split run with different loads and kinds per half, which separates independent halves from shared state.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef struct packed {
        logic       wait_trig;
        logic       snap_en;
        logic       match_en;
        logic       up;
        logic [1:0] kind;
    } mode_t;

    localparam logic [1:0] KIND_PERIODIC = 2'd2;
    localparam int         MODE_W        = 6;
    localparam int         CFG_W         = 3;
    localparam int         EVT_W         = 4;

    localparam int EV_TO_A = 0;
    localparam int EV_MT_A = 1;
    localparam int EV_TO_B = 2;
    localparam int EV_MT_B = 3;

    localparam int W_CFG     = 0;
    localparam int W_CTRL    = 1;
    localparam int W_MODE_A  = 2;
    localparam int W_MODE_B  = 3;
    localparam int W_LOAD_A  = 4;
    localparam int W_LOAD_B  = 5;
    localparam int W_MATCH_A = 6;
    localparam int W_MATCH_B = 7;
    localparam int W_TMR_A   = 8;
    localparam int W_TMR_B   = 9;
    localparam int W_FREE_A  = 10;
    localparam int W_FREE_B  = 11;
    localparam int W_RIS     = 12;
    localparam int W_MASK    = 13;
    localparam int W_CLEAR   = 14;
    localparam int W_MIS     = 15;

endpackage

// File: rtl/gpt_core.sv
module gpt_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         periodic,
    input  logic         up,
    input  logic         match_en,
    input  logic         snap_en,
    input  logic         wait_trig,
    input  logic         trig,
    input  logic [W-1:0] load,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] count,
    output logic [W-1:0] free,
    output logic [W-1:0] snap,
    output logic         timeout,
    output logic         match_hit
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] free;
        logic [W-1:0] snap;
        logic         run;
        logic         en_prev;
    } core_st_t;

    core_st_t st_q, st_d;
    logic start, running, term;

    always_comb begin
        st_d      = st_q;
        start     = en & ~st_q.en_prev;
        running   = en & st_q.run & ~start;
        term      = up ? (st_q.count == load) : (st_q.count == '0);
        timeout   = running & term;
        match_hit = running & match_en & (st_q.count == match_val);
        st_d.en_prev = en;
        if (start) begin
            st_d.count = up ? '0 : load;
            st_d.free  = '0;
            st_d.run   = ~wait_trig;
        end else if (en) begin
            st_d.free = st_q.free + ONE;
            if (!st_q.run && trig) begin
                st_d.run = 1'b1;
            end
            if (running) begin
                if (term) begin
                    if (periodic) begin
                        st_d.count = up ? '0 : load;
                    end
                    if (snap_en) begin
                        st_d.snap = st_q.free;
                    end
                end else begin
                    st_d.count = up ? (st_q.count + ONE) : (st_q.count - ONE);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign free  = st_q.free;
    assign snap  = st_q.snap;

endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] ris,
    output logic [N-1:0] mis,
    output logic         irq
);
    logic [N-1:0] ris_q, ris_d;

    always_comb begin
        ris_d = (ris_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ris_q <= '0;
        end else begin
            ris_q <= ris_d;
        end
    end

    assign ris = ris_q;
    assign mis = ris_q & mask;
    assign irq = |mis;

endmodule

// File: rtl/gp_timer_pair.sv
module gp_timer_pair
    import gpt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [2*HALF_W-1:0]   rd_data,
    input  logic                  trig_a,
    input  logic                  trig_b,
    output logic                  irq
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              en_a;
        logic              en_b;
        mode_t             mode_a;
        mode_t             mode_b;
        logic [HALF_W-1:0] load_a;
        logic [HALF_W-1:0] load_b;
        logic [HALF_W-1:0] match_a;
        logic [HALF_W-1:0] match_b;
        logic [EVT_W-1:0]  mask;
    } regs_t;

    regs_t r_q, r_d;

    logic              wide;
    logic              wr_ok, rd_ok;
    logic [WORD_W-1:0] waddr, raddr;
    logic              lock_a, lock_b, ctrl_wr;
    logic              periodic_a, periodic_b, matchen_a;
    logic              to_a, to_b, hit_a, hit_b, done_a, done_b;
    logic [DATA_W-1:0] cnt_a, free_a, snap_a, load_full_a, match_full_a, tmr_a;
    logic [HALF_W-1:0] cnt_b, free_b, snap_b, tmr_b;
    logic [EVT_W-1:0]  ev_set, ev_clr, ris, mis;

    assign wide       = (r_q.cfg <= CFG_W'(1));
    assign wr_ok      = wr_en & (wr_addr[1:0] == 2'b00);
    assign rd_ok      = (rd_addr[1:0] == 2'b00);
    assign waddr      = wr_addr[ADDR_W-1:2];
    assign raddr      = rd_addr[ADDR_W-1:2];
    assign lock_a     = r_q.en_a;
    assign lock_b     = r_q.en_b | (wide & r_q.en_a);
    assign ctrl_wr    = wr_ok & (int'(waddr) == W_CTRL);
    assign periodic_a = (r_q.mode_a.kind == KIND_PERIODIC);
    assign periodic_b = (r_q.mode_b.kind == KIND_PERIODIC);
    assign matchen_a  = r_q.mode_a.match_en;
    assign done_a     = to_a & ~periodic_a;
    assign done_b     = to_b & ~periodic_b;

    assign load_full_a  = {(wide ? r_q.load_b  : {HALF_W{1'b0}}), r_q.load_a};
    assign match_full_a = {(wide ? r_q.match_b : {HALF_W{1'b0}}), r_q.match_a};

    // register write path
    always_comb begin
        r_d = r_q;
        if (done_a) r_d.en_a = 1'b0;
        if (done_b) r_d.en_b = 1'b0;
        if (wr_ok) begin
            case (int'(waddr))
                W_CFG: begin
                    if (!(r_q.en_a || r_q.en_b)) r_d.cfg = wr_data[CFG_W-1:0];
                end
                W_CTRL: begin
                    r_d.en_a = wr_data[0];
                    r_d.en_b = wr_data[1];
                end
                W_MODE_A: begin
                    if (!lock_a) r_d.mode_a = mode_t'(wr_data[MODE_W-1:0]);
                end
                W_MODE_B: begin
                    if (!lock_b) r_d.mode_b = mode_t'(wr_data[MODE_W-1:0]);
                end
                W_LOAD_A: begin
                    if (!lock_a) begin
                        r_d.load_a = wr_data[HALF_W-1:0];
                        if (wide) r_d.load_b = wr_data[DATA_W-1:HALF_W];
                    end
                end
                W_LOAD_B: begin
                    if (!lock_b) r_d.load_b = wr_data[HALF_W-1:0];
                end
                W_MATCH_A: begin
                    if (!lock_a) begin
                        r_d.match_a = wr_data[HALF_W-1:0];
                        if (wide) r_d.match_b = wr_data[DATA_W-1:HALF_W];
                    end
                end
                W_MATCH_B: begin
                    if (!lock_b) r_d.match_b = wr_data[HALF_W-1:0];
                end
                W_MASK: begin
                    r_d.mask = wr_data[EVT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    gpt_core #(.W(DATA_W)) i_core_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (r_q.en_a),
        .periodic  (periodic_a),
        .up        (r_q.mode_a.up),
        .match_en  (r_q.mode_a.match_en),
        .snap_en   (r_q.mode_a.snap_en),
        .wait_trig (r_q.mode_a.wait_trig),
        .trig      (trig_a),
        .load      (load_full_a),
        .match_val (match_full_a),
        .count     (cnt_a),
        .free      (free_a),
        .snap      (snap_a),
        .timeout   (to_a),
        .match_hit (hit_a)
    );

    gpt_core #(.W(HALF_W)) i_core_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (r_q.en_b & ~wide),
        .periodic  (periodic_b),
        .up        (r_q.mode_b.up),
        .match_en  (r_q.mode_b.match_en),
        .snap_en   (r_q.mode_b.snap_en),
        .wait_trig (r_q.mode_b.wait_trig),
        .trig      (trig_b),
        .load      (r_q.load_b),
        .match_val (r_q.match_b),
        .count     (cnt_b),
        .free      (free_b),
        .snap      (snap_b),
        .timeout   (to_b),
        .match_hit (hit_b)
    );

    assign ev_set = {hit_b, to_b, hit_a, to_a};
    assign ev_clr = (wr_ok && int'(waddr) == W_CLEAR) ? wr_data[EVT_W-1:0] : '0;

    gpt_irq #(.N(EVT_W)) i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (ev_clr),
        .mask  (r_q.mask),
        .ris   (ris),
        .mis   (mis),
        .irq   (irq)
    );

    assign tmr_a = r_q.mode_a.snap_en ? snap_a : cnt_a;
    assign tmr_b = r_q.mode_b.snap_en ? snap_b : cnt_b;

    function automatic logic [DATA_W-1:0] fit(input logic joined, input logic [DATA_W-1:0] v);
        return joined ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    endfunction

    // register read path
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            case (int'(raddr))
                W_CFG:     rd_data = DATA_W'(r_q.cfg);
                W_CTRL:    rd_data = DATA_W'({r_q.en_b, r_q.en_a});
                W_MODE_A:  rd_data = DATA_W'(r_q.mode_a);
                W_MODE_B:  rd_data = DATA_W'(r_q.mode_b);
                W_LOAD_A:  rd_data = fit(wide, load_full_a);
                W_LOAD_B:  rd_data = DATA_W'(r_q.load_b);
                W_MATCH_A: rd_data = fit(wide, match_full_a);
                W_MATCH_B: rd_data = DATA_W'(r_q.match_b);
                W_TMR_A:   rd_data = fit(wide, tmr_a);
                W_TMR_B:   rd_data = DATA_W'(tmr_b);
                W_FREE_A:  rd_data = fit(wide, free_a);
                W_FREE_B:  rd_data = DATA_W'(free_b);
                W_RIS:     rd_data = DATA_W'(ris);
                W_MASK:    rd_data = DATA_W'(r_q.mask);
                W_MIS:     rd_data = DATA_W'(mis);
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_a,
    input logic              en_b,
    input logic              ctrl_wr,
    input logic              to_a,
    input logic              periodic_a,
    input logic              matchen_a,
    input logic              wide,
    input logic [2:0]        cfg,
    input logic [3:0]        ris,
    input logic [HALF_W-1:0] cnt_b,
    input logic              irq
);

    // R6: a one-shot time-out drops the enable bit unless software rewrites it
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (to_a && !periodic_a && !ctrl_wr) |=> !en_a);

    // R8: a new match flag needs match enable in the cycle before
    p_match_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris[1]) |-> $past(matchen_a));

    // R12: configuration does not change while a half is enabled
    p_cfg_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a || en_b) |=> (cfg == $past(cfg)));

    // R13: the B counter stays idle in joined mode
    p_b_idle_joined_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> $stable(cnt_b));

    // R11: an interrupt always has a raw status source
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ris != 4'b0000));

endmodule

bind gp_timer_pair gpt_checker #(.HALF_W(HALF_W)) i_gpt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_a       (r_q.en_a),
    .en_b       (r_q.en_b),
    .ctrl_wr    (ctrl_wr),
    .to_a       (to_a),
    .periodic_a (periodic_a),
    .matchen_a  (matchen_a),
    .wide       (wide),
    .cfg        (r_q.cfg),
    .ris        (ris),
    .cnt_b      (cnt_b),
    .irq        (irq)
);

// File: tb/test_gp_timer_pair.sv
`timescale 1ns/1ps
module test_gp_timer_pair;
    localparam logic [5:0] A_CFG = 6'h00, A_CTRL = 6'h04, A_MODE_A = 6'h08, A_MODE_B = 6'h0C;
    localparam logic [5:0] A_LOAD_A = 6'h10, A_LOAD_B = 6'h14, A_MATCH_A = 6'h18;
    localparam logic [5:0] A_TMR_A = 6'h20, A_FREE_A = 6'h28, A_RIS = 6'h30;
    localparam logic [5:0] A_MASK = 6'h34, A_CLEAR = 6'h38, A_MIS = 6'h3C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [5:0]  wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [5:0]  rd_addr = 0;
    logic [31:0] rd_data;
    logic        trig_a = 0;
    logic        trig_b = 0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int wcyc = 0;

    gp_timer_pair i_gp_timer_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #1200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
        wcyc = cyc;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_ris(input int b, input int maxc, output int t);
        t = -1000;
        rd_addr = A_RIS;
        for (int i = 0; i < maxc; i++) begin
            @(posedge clk); #1;
            if (rd_data[b]) begin
                t = cyc;
                break;
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        int k, t, t2;
        int loads [5] = '{0, 1, 2, 5, 9};

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1 reset state
        rd(A_CFG, v);  check("R1 cfg", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_RIS, v);  check("R1 ris", v, 0);
        rd(A_MIS, v);  check("R1 mis", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 joined load mapping
        wr(A_LOAD_A, 32'h0003_0005);
        rd(A_LOAD_B, v); check("R2 load_b upper", v, 32'h3);
        rd(A_LOAD_A, v); check("R2 load_a full", v, 32'h0003_0005);

        // R3 joined count crosses half boundary
        wr(A_MODE_A, 32'h2);
        wr(A_LOAD_A, 32'h0002_0001);
        wr(A_CTRL, 1);
        repeat (3) @(posedge clk);
        #1 rd(A_TMR_A, v); check("R3 joined count", v, 32'h0001_FFFF);
        wr(A_CTRL, 0);

        // R4 R5 R6 R7 sweep
        for (int up = 0; up < 2; up++) begin
            for (int per = 0; per < 2; per++) begin
                for (int li = 0; li < 5; li++) begin
                    int l = loads[li];
                    wr(A_CTRL, 0);
                    wr(A_CLEAR, 32'hF);
                    wr(A_MODE_A, (per ? 32'h2 : 32'h1) | (up ? 32'h4 : 32'h0));
                    wr(A_LOAD_A, l);
                    wr(A_CTRL, 1);
                    k = wcyc;
                    wait_ris(0, 40, t);
                    check(up ? "R5 first timeout latency" : "R4 first timeout latency", t - k, l + 2);
                    if (!per) begin
                        rd(A_CTRL, v); check("R6 enable cleared", v, 0);
                        rd(A_TMR_A, v); check("R6 terminal count", v, up ? l : 0);
                        wr(A_CLEAR, 1);
                        repeat (l + 4) @(posedge clk);
                        #1 rd(A_RIS, v); check("R6 no second timeout", v & 1, 0);
                    end else if (l >= 1) begin
                        wr(A_CLEAR, 1);
                        wait_ris(0, 40, t2);
                        check("R7 period", t2 - t, l + 1);
                    end
                end
            end
        end

        // R8 match, down and up, and disabled
        wr(A_CTRL, 0); wr(A_CLEAR, 32'hF);
        wr(A_MODE_A, 32'h0A); wr(A_LOAD_A, 10); wr(A_MATCH_A, 4);
        wr(A_CTRL, 1); k = wcyc;
        wait_ris(1, 40, t); check("R8 match down latency", t - k, 8);
        wr(A_CTRL, 0); wr(A_CLEAR, 32'hF);
        wr(A_MODE_A, 32'h0E);
        wr(A_CTRL, 1); k = wcyc;
        wait_ris(1, 40, t); check("R8 match up latency", t - k, 6);
        wr(A_CTRL, 0); wr(A_CLEAR, 32'hF);
        wr(A_MODE_A, 32'h02);
        wr(A_CTRL, 1);
        repeat (25) @(posedge clk);
        #1 rd(A_RIS, v); check("R8 no match when disabled", v & 32'h3, 32'h1);

        // R9 snapshot
        wr(A_CTRL, 0); wr(A_CLEAR, 32'hF);
        wr(A_MODE_A, 32'h11); wr(A_LOAD_A, 6);
        wr(A_CTRL, 1); k = wcyc;
        wait_ris(0, 40, t); check("R9 latency", t - k, 8);
        rd(A_TMR_A, v);  check("R9 snapshot value", v, 6);
        rd(A_FREE_A, v); check("R9 free-running value", v, 7);

        // R11 mask and clear
        check("R11 irq masked off", {31'd0, irq}, 0);
        rd(A_MIS, v); check("R11 mis masked off", v, 0);
        wr(A_MASK, 1);
        check("R11 irq unmasked", {31'd0, irq}, 1);
        rd(A_MIS, v); check("R11 mis unmasked", v, 1);
        wr(A_CLEAR, 1);
        rd(A_RIS, v); check("R11 cleared", v, 0);
        check("R11 irq after clear", {31'd0, irq}, 0);
        wr(A_MASK, 0);

        // R10 wait on trigger with snapshot
        wr(A_CTRL, 0); wr(A_CLEAR, 32'hF);
        wr(A_MODE_A, 32'h31); wr(A_LOAD_A, 3);
        wr(A_CTRL, 1); k = wcyc;
        repeat (3) @(posedge clk);
        #1 trig_a = 1;
        @(posedge clk);
        #1 trig_a = 0;
        wait_ris(0, 40, t); check("R10 latency after trigger", t - k, 8);
        rd(A_TMR_A, v); check("R10 snapshot with wait", v, 6);

        // R12 configuration lock
        wr(A_CTRL, 0); wr(A_MODE_A, 32'h2); wr(A_LOAD_A, 50);
        wr(A_CTRL, 1);
        wr(A_LOAD_A, 7);
        rd(A_LOAD_A, v); check("R12 load locked", v, 50);
        wr(A_CFG, 4);
        rd(A_CFG, v); check("R12 cfg locked", v, 0);
        wr(A_CTRL, 0);
        wr(A_LOAD_A, 7);
        rd(A_LOAD_A, v); check("R12 load unlocked", v, 7);

        // R13 split mode
        wr(A_CFG, 4);
        rd(A_CFG, v); check("R13 cfg split", v, 4);
        wr(A_MODE_A, 32'h2); wr(A_MODE_B, 32'h5);
        wr(A_LOAD_B, 5);
        wr(A_LOAD_A, 32'h0009_0003);
        rd(A_LOAD_B, v); check("R13 load_b untouched", v, 5);
        rd(A_LOAD_A, v); check("R13 load_a low half", v, 3);
        wr(A_CLEAR, 32'hF);
        wr(A_CTRL, 3); k = wcyc;
        wait_ris(0, 40, t); check("R13 A timeout", t - k, 5);
        wait_ris(2, 40, t); check("R13 B timeout", t - k, 7);
        rd(A_CTRL, v); check("R13 only B cleared", v, 1);
        wr(A_CTRL, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule